// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a bank of external interrupt lines and hands each one to a single processor context on a chosen request pin. Every source has its own sense setting: level (active-high or active-low), single edge (rising or falling) or dual edge. Edge events are held in a pending latch until software acknowledges them. Software can also raise or drop any source's pending state by index through a single injection register.

Software works through a simple write port and a registered read port. A source reaches a request pin only when three things are all true: it is pending, it is unmasked, and the bit for that context is set in its context map. Its pin map must also be enabled. Each context has a small group of request pins. Every pin is the registered OR of all sources delivered to it.

Top module: `shared_irq_ctrl`

## Requirements
- R1: Reading address 0x00 returns the configuration word. Bits [7:0] hold G, and the source count is (G+1)*8. Bits [15:8] hold C, and the context count is C+1. All other bits are zero.
- R2: After reset all sources are masked, level-sensitive, active-high and not dual-edge. No source is pending and every request output is low.
- R3: A write to 0x01 sets the mask-enable bit of each source whose data bit is one. A write to 0x02 clears the mask-enable bit of each source whose data bit is one. Zero bits leave the other sources unchanged. The mask state reads back at 0x09.
- R4: Trigger register 0x04 selects the mode per source: bit 0 is level, bit 1 is edge. In level mode, polarity register 0x03 selects the active level: 0 is active-high, 1 is active-low. The pending state follows the line.
- R5: In edge mode, a polarity bit of 0 latches pending on a rising edge and a polarity bit of 1 latches it on a falling edge. The opposite edge has no effect. The latch holds after the line returns.
- R6: With dual register 0x05 set and edge mode selected, both edges latch pending and polarity is ignored.
- R7: A write to 0x06 with bit 31 set marks the source indexed by the low data bits pending. A write with bit 31 clear clears that source's latch, which is the acknowledge for edge sources.
- R8: If an injection clear and an active hardware edge reach the same source in the same cycle, the edge wins and pending stays set.
- R9: The raw pending vector reads back at 0x07 regardless of mask. The pending-and-unmasked vector reads back at 0x08. A source drives a request pin only when it is pending, unmasked and its context-map bit for that context is set.
- R10: Address 0x20+i is the pin map of source i: bit 31 enables it and the low bits give the pin number. Address 0x40+i is its one-hot context map. Output bit c*PINS+p is the registered OR of all sources delivered to pin p of context c. A disabled pin map delivers nothing.

Line inputs pass through a two-flop synchronizer before sensing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line | input | SRCS | External interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 7 | Read address |
| rd_data | output | 32 | Registered read data |
| irq_req | output | CTXS*PINS | Request pins, context-major |

## Verification
The collision of interest is an injection-register clear and a hardware edge landing on the same source in the same cycle. The bench first marks a source pending through an injection set. It then raises the line at a clock edge counted so that the synchronized edge is seen in exactly the cycle in which the clear write is taken. Pending read back afterwards must still be one. A following clear with no edge must drop it to zero, which shows the clear alone does work.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int AW = 7;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_CFG    = 7'h00;
  localparam logic [AW-1:0] A_MSET   = 7'h01;
  localparam logic [AW-1:0] A_MCLR   = 7'h02;
  localparam logic [AW-1:0] A_POL    = 7'h03;
  localparam logic [AW-1:0] A_TRIG   = 7'h04;
  localparam logic [AW-1:0] A_DUAL   = 7'h05;
  localparam logic [AW-1:0] A_INJECT = 7'h06;
  localparam logic [AW-1:0] A_PEND   = 7'h07;
  localparam logic [AW-1:0] A_MPEND  = 7'h08;
  localparam logic [AW-1:0] A_MASK   = 7'h09;
  localparam logic [AW-1:0] A_PINMAP = 7'h20;
  localparam logic [AW-1:0] A_CTXMAP = 7'h40;
  localparam int INJ_SET_BIT = 31;
  localparam int MAP_EN_BIT  = 31;
endpackage

// File: rtl/sirq_sense.sv
module sirq_sense (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic pol_i,
  input  logic trig_i,
  input  logic dual_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic pend_o
);
  logic s1_q, s2_q, prev_q, latch_q;
  logic rise, fall, edge_ev, active;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    rise    = s2_q & ~prev_q;
    fall    = ~s2_q & prev_q;
    active  = s2_q ^ pol_i;
    edge_ev = trig_i & (dual_i ? (rise | fall) : (pol_i ? fall : rise));
  end

  always_ff @(posedge clk) begin
    if (rst) latch_q <= 1'b0;
    else     latch_q <= edge_ev | sw_set_i | (latch_q & ~sw_clr_i);
  end

  assign pend_o = latch_q | (~trig_i & active);

  // R8
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    edge_ev |=> latch_q);
  // R7
  inject_set_chk: assert property (@(posedge clk) disable iff (rst)
    sw_set_i |=> latch_q);
  // R7
  inject_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_clr_i && !sw_set_i && !edge_ev) |=> !latch_q);
endmodule

// File: rtl/sirq_route.sv
module sirq_route #(
  parameter int SRCS  = 16,
  parameter int CTXS  = 2,
  parameter int PINS  = 4,
  parameter int PIN_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SRCS-1:0]         pend_i,
  input  logic [SRCS-1:0]         mask_i,
  input  logic [SRCS-1:0]         map_en_i,
  input  logic [SRCS*PIN_W-1:0]   pin_i,
  input  logic [SRCS*CTXS-1:0]    ctx_i,
  output logic [CTXS*PINS-1:0]    irq_o
);
  localparam int OUTS = CTXS * PINS;
  logic [OUTS-1:0] irq_d, irq_q;

  always_comb begin
    irq_d = '0;
    for (int s = 0; s < SRCS; s++) begin
      for (int c = 0; c < CTXS; c++) begin
        for (int p = 0; p < PINS; p++) begin
          if (pend_i[s] && mask_i[s] && map_en_i[s] && ctx_i[s*CTXS+c] &&
              (pin_i[s*PIN_W +: PIN_W] == PIN_W'(p)))
            irq_d[c*PINS+p] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R9
  deliver_src_chk: assert property (@(posedge clk) disable iff (rst)
    (|irq_q) |-> $past(|(pend_i & mask_i & map_en_i)));
  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (irq_q == '0));
endmodule

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl
  import sirq_pkg::*;
#(
  parameter int GROUPS = 2,
  parameter int CTXS   = 2,
  parameter int PINS   = 4,
  localparam int SRCS  = GROUPS * 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SRCS-1:0]      irq_line,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic [AW-1:0]        rd_addr,
  output logic [DW-1:0]        rd_data,
  output logic [CTXS*PINS-1:0] irq_req
);
  localparam int PIN_W = (PINS > 1) ? $clog2(PINS) : 1;
  localparam int SRC_W = (SRCS > 1) ? $clog2(SRCS) : 1;

  logic [SRCS-1:0]       mask_q, pol_q, trig_q, dual_q, map_en_q, pend;
  logic [SRCS*PIN_W-1:0] pin_q;
  logic [SRCS*CTXS-1:0]  ctx_q;
  logic [SRCS-1:0]       inj_set, inj_clr;
  logic                  inj_wr;
  logic [SRC_W-1:0]      inj_idx;

  assign inj_wr  = wr_en && (wr_addr == A_INJECT) &&
                   (wr_data[DW-2:0] < (DW-1)'(SRCS));
  assign inj_idx = wr_data[SRC_W-1:0];

  always_comb begin
    inj_set = '0;
    inj_clr = '0;
    if (inj_wr) begin
      inj_set[inj_idx] = wr_data[INJ_SET_BIT];
      inj_clr[inj_idx] = ~wr_data[INJ_SET_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      pol_q    <= '0;
      trig_q   <= '0;
      dual_q   <= '0;
      map_en_q <= '0;
      pin_q    <= '0;
      ctx_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_MSET: mask_q <= mask_q | wr_data[SRCS-1:0];
        A_MCLR: mask_q <= mask_q & ~wr_data[SRCS-1:0];
        A_POL:  pol_q  <= wr_data[SRCS-1:0];
        A_TRIG: trig_q <= wr_data[SRCS-1:0];
        A_DUAL: dual_q <= wr_data[SRCS-1:0];
        default: begin
          for (int i = 0; i < SRCS; i++) begin
            if (wr_addr == A_PINMAP + AW'(i)) begin
              map_en_q[i]              <= wr_data[MAP_EN_BIT];
              pin_q[i*PIN_W +: PIN_W]  <= wr_data[PIN_W-1:0];
            end
            if (wr_addr == A_CTXMAP + AW'(i))
              ctx_q[i*CTXS +: CTXS] <= wr_data[CTXS-1:0];
          end
        end
      endcase
    end
  end

  for (genvar g = 0; g < SRCS; g++) begin : g_src
    sirq_sense u_sense (
      .clk      (clk),
      .rst      (rst),
      .line_i   (irq_line[g]),
      .pol_i    (pol_q[g]),
      .trig_i   (trig_q[g]),
      .dual_i   (dual_q[g]),
      .sw_set_i (inj_set[g]),
      .sw_clr_i (inj_clr[g]),
      .pend_o   (pend[g])
    );
  end

  sirq_route #(.SRCS(SRCS), .CTXS(CTXS), .PINS(PINS), .PIN_W(PIN_W)) u_route (
    .clk      (clk),
    .rst      (rst),
    .pend_i   (pend),
    .mask_i   (mask_q),
    .map_en_i (map_en_q),
    .pin_i    (pin_q),
    .ctx_i    (ctx_q),
    .irq_o    (irq_req)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      rd_data <= '0;
      case (rd_addr)
        A_CFG:   rd_data <= {16'h0, 8'(CTXS-1), 8'(GROUPS-1)};
        A_POL:   rd_data[SRCS-1:0] <= pol_q;
        A_TRIG:  rd_data[SRCS-1:0] <= trig_q;
        A_DUAL:  rd_data[SRCS-1:0] <= dual_q;
        A_PEND:  rd_data[SRCS-1:0] <= pend;
        A_MPEND: rd_data[SRCS-1:0] <= pend & mask_q;
        A_MASK:  rd_data[SRCS-1:0] <= mask_q;
        default: begin
          for (int i = 0; i < SRCS; i++) begin
            if (rd_addr == A_PINMAP + AW'(i)) begin
              rd_data[MAP_EN_BIT]  <= map_en_q[i];
              rd_data[PIN_W-1:0]   <= pin_q[i*PIN_W +: PIN_W];
            end
            if (rd_addr == A_CTXMAP + AW'(i))
              rd_data[CTXS-1:0] <= ctx_q[i*CTXS +: CTXS];
          end
        end
      endcase
    end
  end

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_MSET) |=>
      ((mask_q & $past(wr_data[SRCS-1:0])) == $past(wr_data[SRCS-1:0])));
  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_MCLR) |=>
      ((mask_q & $past(wr_data[SRCS-1:0])) == '0));
endmodule

// File: tb/test_shared_irq_ctrl.sv
module test_shared_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SRCS = 16;
  localparam int OUTS = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [SRCS-1:0] irq_line = '0;
  logic            wr_en = 1'b0;
  logic [6:0]      wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [6:0]      rd_addr = '0;
  logic [31:0]     rd_data;
  logic [OUTS-1:0] irq_req;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_irq_ctrl i_shared_irq_ctrl (
    .clk(clk), .rst(rst), .irq_line(irq_line), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_req(irq_req)
  );

  // level-mode vectors: {pol, line, unmask, expected request}
  localparam logic [3:0] LVL_TAB [8] = '{
    4'b0111, 4'b0010, 4'b1011, 4'b1110,
    4'b0100, 4'b1000, 4'b0111, 4'b1110
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R2 reset state
    check("R2 outputs", 32'(irq_req), 0);
    rd(7'h09, v); check("R2 mask", v, 0);
    rd(7'h07, v); check("R2 pending", v, 0);
    rd(7'h04, v); check("R2 trigger", v, 0);
    rd(7'h03, v); check("R2 polarity", v, 0);
    // R1 config word
    rd(7'h00, v); check("R1 config", v, 32'h0000_0101);

    // R3 mask set/clear
    wr(7'h01, 32'h0000_00A5);
    wr(7'h01, 32'h0000_0100);
    rd(7'h09, v); check("R3 set", v, 32'h1A5);
    wr(7'h02, 32'h0000_0021);
    rd(7'h09, v); check("R3 clear", v, 32'h184);
    wr(7'h02, 32'hFFFF_FFFF);

    // R10 route source 0 to ctx0 pin1
    wr(7'h20, 32'h8000_0001);
    wr(7'h40, 32'h1);
    // R4 level table
    for (int k = 0; k < 8; k++) begin
      wr(7'h03, {31'b0, LVL_TAB[k][3]});
      if (LVL_TAB[k][1]) wr(7'h01, 32'h1); else wr(7'h02, 32'h1);
      irq_line[0] = LVL_TAB[k][2];
      cyc(5);
      check($sformatf("R4 level vec %0d", k), 32'(irq_req[1]), 32'(LVL_TAB[k][0]));
    end
    irq_line[0] = 1'b0;
    wr(7'h03, 32'h0);
    wr(7'h02, 32'h1);
    cyc(4);

    // R5 falling-edge source 1
    wr(7'h04, 32'h0002);
    wr(7'h03, 32'h0002);
    irq_line[1] = 1'b1; cyc(5);
    rd(7'h07, v); check("R5 opposite edge ignored", 32'(v[1]), 0);
    irq_line[1] = 1'b0; cyc(5);
    rd(7'h07, v); check("R5 falling latched", 32'(v[1]), 1);
    cyc(5);
    rd(7'h07, v); check("R5 latch holds", 32'(v[1]), 1);
    // R7 acknowledge
    wr(7'h06, 32'h0000_0001);
    rd(7'h07, v); check("R7 clear ack", 32'(v[1]), 0);

    // R6 dual edge source 3, polarity set yet ignored
    wr(7'h04, 32'h000A);
    wr(7'h03, 32'h000A);
    wr(7'h05, 32'h0008);
    irq_line[3] = 1'b1; cyc(5);
    rd(7'h07, v); check("R6 rise", 32'(v[3]), 1);
    wr(7'h06, 32'h0000_0003);
    rd(7'h07, v); check("R6 cleared", 32'(v[3]), 0);
    irq_line[3] = 1'b0; cyc(5);
    rd(7'h07, v); check("R6 fall", 32'(v[3]), 1);
    wr(7'h06, 32'h0000_0003);

    // R8 edge vs clear in same cycle, source 2 rising edge
    wr(7'h04, 32'h000E);
    wr(7'h06, 32'h8000_0002);
    rd(7'h07, v); check("R7 inject set", 32'(v[2]), 1);
    @(negedge clk); irq_line[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'h06; wr_data = 32'h0000_0002;
    @(negedge clk); wr_en = 1'b0;
    rd(7'h07, v); check("R8 edge wins", 32'(v[2]), 1);
    wr(7'h06, 32'h0000_0002);
    rd(7'h07, v); check("R8 plain clear", 32'(v[2]), 0);

    // R9 / R10 source 4 to ctx1 pin3
    wr(7'h06, 32'h8000_0004);
    rd(7'h07, v); check("R9 pending while masked", 32'(v[4]), 1);
    rd(7'h08, v); check("R9 masked-pending off", 32'(v[4]), 0);
    wr(7'h24, 32'h8000_0003);
    wr(7'h44, 32'h2);
    cyc(2);
    check("R9 masked no request", 32'(irq_req), 0);
    wr(7'h01, 32'h0010);
    rd(7'h08, v); check("R9 masked-pending on", 32'(v[4]), 1);
    cyc(1);
    check("R10 ctx1 pin3", 32'(irq_req), 32'h80);
    wr(7'h24, 32'h0000_0003);
    cyc(2);
    check("R10 map disabled", 32'(irq_req), 0);
    wr(7'h24, 32'h8000_0003);
    wr(7'h44, 32'h0);
    cyc(2);
    check("R9 no context bit", 32'(irq_req), 0);
    wr(7'h44, 32'h1);
    cyc(2);
    check("R10 ctx0 pin3", 32'(irq_req), 32'h08);
    wr(7'h06, 32'h0000_0004);
    cyc(2);
    check("R7 clear drops request", 32'(irq_req), 0);

    finish_run();
  end
endmodule